// File: doc/BRIEF.md
# Programmable Bus Clock Divider

This block derives a slow peripheral bus clock from the fast core clock. A 5-bit divide code N selects a ratio of N+1, so one bus clock period spans N+1 core cycles. When the ratio is even the output has an exact 50% duty cycle. When the ratio is odd the high phase is one core cycle longer than the low phase.

Besides the clock itself, the block drives two single-cycle strobes in the core clock domain. One marks each rising transition of the bus clock and the other marks each falling transition. A downstream bus sequencer times its events from these strobes without having to sample the divided clock.

Code zero is illegal. Loading it raises a flag, and the output stops low at the end of the period in progress. A legal code loaded while the clock runs is held back until the period in progress ends, so no shortened or stretched pulse is ever produced.

Top module: `busclk_divider`

## Requirements
- R1: With a legal active code N, rising edges of the bus clock are exactly N+1 core cycles apart.
- R2: For an odd code N (even ratio), the high phase and the low phase each last (N+1)/2 core cycles.
- R3: For an even nonzero code N (odd ratio), the high phase lasts (N+2)/2 core cycles and the low phase lasts N/2 core cycles.
- R4: Code 1 makes the bus clock alternate every core cycle, giving half the core frequency.
- R5: Code 31 gives a period of 32 core cycles, with 16 cycles high and 16 cycles low.
- R6: After a load of code 0, the illegal flag is high from the next cycle on. The period in progress finishes, and the bus clock then stays low with no rising edge until a legal code is loaded.
- R7: A load of a legal code clears the illegal flag in the next cycle. If the output is stopped, the bus clock goes high in the cycle right after the load cycle.
- R8: A code loaded while the clock runs takes effect at the next period boundary, and the period in progress completes under the old code. If several loads arrive before the boundary, the last one wins. A load presented in the final core cycle of a period governs the period that starts next.
- R9: The rise strobe is high for exactly the one core cycle in which the bus clock has just gone from low to high, and the fall strobe likewise for high to low. Cycles that follow a reset edge are excluded.
- R10: Synchronous reset leaves the bus clock low, both strobes low, the flag low and the output stopped until a code is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Synchronous reset, active high |
| div_code_i | input | 5 | Divide code N, ratio N+1 |
| div_load_i | input | 1 | Strobe that captures div_code_i |
| bus_clk_o | output | 1 | Divided bus clock |
| rise_stb_o | output | 1 | One-cycle strobe on a rising bus clock transition |
| fall_stb_o | output | 1 | One-cycle strobe on a falling bus clock transition |
| code_bad_o | output | 1 | High while the last loaded code is zero |

## Verification
The bench builds the block with its default 5-bit code width. That width puts every legal ratio in reach, from divide-by-2 up to the divide-by-32 ceiling, and lets one vector table sweep both duty cycle cases together with the two extreme codes. At this width the longest period is only 32 cycles, so the bench can also place a load in a chosen cycle of a period. It does so for the high phase, the low phase and the final cycle before a boundary, and for a zero code loaded while the clock runs.

// File: rtl/busclk_pkg.sv
package busclk_pkg;

    // Operating mode of the waveform generator
    typedef enum logic {
        WAVE_IDLE = 1'b0,
        WAVE_RUN  = 1'b1
    } wave_mode_e;

endpackage

// File: rtl/busclk_phase_calc.sv
// Turns a divide code into the terminal count of a period and the
// number of cycles the output stays high (high gets the spare cycle
// when the ratio is odd).
module busclk_phase_calc #(
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] last_o,
    output logic [CODE_W-1:0] high_o
);

    localparam int SUM_W = CODE_W + 1;

    logic [SUM_W-1:0] ratio_plus1;

    always_comb begin
        // (code + 1) + 1, halved: ceil(ratio / 2)
        ratio_plus1 = {1'b0, code_i} + SUM_W'(2);
        last_o      = code_i;
        high_o      = ratio_plus1[SUM_W-1:1];
    end

endmodule

// File: rtl/busclk_code_stage.sv
// Holds the active divide code, a pending code waiting for the next
// period boundary, and the illegal-code flag.
module busclk_code_stage #(
    parameter int CODE_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              load_i,
    input  logic              boundary_i,
    output logic [CODE_W-1:0] act_code_o,
    output logic [CODE_W-1:0] next_code_o,
    output logic              bad_o
);

    typedef struct packed {
        logic [CODE_W-1:0] act;
        logic [CODE_W-1:0] pend;
        logic              pend_v;
        logic              bad;
    } stage_t;

    stage_t stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;

        // newest request wins: live load, then pending, then current
        if (load_i) begin
            next_code_o = code_i;
        end else if (stage_q.pend_v) begin
            next_code_o = stage_q.pend;
        end else begin
            next_code_o = stage_q.act;
        end

        if (load_i) begin
            stage_d.bad = (code_i == '0);
        end

        if (boundary_i) begin
            stage_d.act    = next_code_o;
            stage_d.pend_v = 1'b0;
        end else if (load_i) begin
            stage_d.pend   = code_i;
            stage_d.pend_v = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign act_code_o = stage_q.act;
    assign bad_o      = stage_q.bad;

    // R8: the active code only moves on a period boundary
    assert_code_at_boundary_R8: assert property (
        @(posedge clk_i) disable iff (rst_i)
        (stage_q.act != $past(stage_q.act)) |-> $past(boundary_i)
    );

    // R6 / R7: the flag reflects the code seen in the last load
    assert_flag_tracks_load_R6: assert property (
        @(posedge clk_i) disable iff (rst_i)
        load_i |=> (bad_o == ($past(code_i) == '0))
    );

endmodule

// File: rtl/busclk_wave.sv
// Period counter, output clock register and edge strobes.
module busclk_wave
    import busclk_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [CODE_W-1:0] act_last_i,
    input  logic [CODE_W-1:0] act_high_i,
    input  logic [CODE_W-1:0] next_code_i,
    output logic              boundary_o,
    output logic              bus_clk_o,
    output logic              rise_o,
    output logic              fall_o
);

    typedef struct packed {
        wave_mode_e        mode;
        logic [CODE_W-1:0] cnt;
        logic              clk;
        logic              rise;
        logic              fall;
    } wave_t;

    wave_t wave_d, wave_q;
    logic [CODE_W-1:0] cnt_inc;

    assign boundary_o = (wave_q.mode == WAVE_IDLE) || (wave_q.cnt == act_last_i);

    always_comb begin
        wave_d  = wave_q;
        cnt_inc = wave_q.cnt + CODE_W'(1);

        if (boundary_o) begin
            wave_d.cnt = '0;
            if (next_code_i == '0) begin
                wave_d.mode = WAVE_IDLE;
                wave_d.clk  = 1'b0;
            end else begin
                wave_d.mode = WAVE_RUN;
                wave_d.clk  = 1'b1;
            end
        end else begin
            wave_d.cnt = cnt_inc;
            wave_d.clk = (cnt_inc < act_high_i);
        end

        wave_d.rise = wave_d.clk & ~wave_q.clk;
        wave_d.fall = ~wave_d.clk & wave_q.clk;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wave_q <= '0;
        end else begin
            wave_q <= wave_d;
        end
    end

    assign bus_clk_o = wave_q.clk;
    assign rise_o    = wave_q.rise;
    assign fall_o    = wave_q.fall;

    // R1: a period never runs past the active terminal count
    assert_cnt_in_period_R1: assert property (
        @(posedge clk_i) disable iff (rst_i)
        (wave_q.mode == WAVE_RUN) |-> (wave_q.cnt <= act_last_i)
    );

    // R1: every rising edge opens a fresh period
    assert_rise_starts_period_R1: assert property (
        @(posedge clk_i) disable iff (rst_i)
        rise_o |-> (wave_q.cnt == '0 && wave_q.mode == WAVE_RUN)
    );

    // R2 / R3: the fall lands exactly after the high phase length
    assert_fall_at_high_len_R3: assert property (
        @(posedge clk_i) disable iff (rst_i)
        fall_o |-> (wave_q.cnt == act_high_i)
    );

    // R6: a stopped generator keeps the clock low
    assert_idle_low_R6: assert property (
        @(posedge clk_i) disable iff (rst_i)
        (wave_q.mode == WAVE_IDLE) |-> !bus_clk_o
    );

    // R9: strobes never overlap and each lasts one cycle
    assert_strobes_exclusive_R9: assert property (
        @(posedge clk_i) disable iff (rst_i)
        $onehot0({rise_o, fall_o})
    );

    assert_rise_single_R9: assert property (
        @(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o
    );

endmodule

// File: rtl/busclk_divider.sv
module busclk_divider #(
    parameter int CODE_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [CODE_W-1:0] div_code_i,
    input  logic              div_load_i,
    output logic              bus_clk_o,
    output logic              rise_stb_o,
    output logic              fall_stb_o,
    output logic              code_bad_o
);

    logic [CODE_W-1:0] act_code;
    logic [CODE_W-1:0] next_code;
    logic [CODE_W-1:0] act_last;
    logic [CODE_W-1:0] act_high;
    logic              boundary;

    busclk_code_stage #(
        .CODE_W (CODE_W)
    ) i_code_stage (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .code_i      (div_code_i),
        .load_i      (div_load_i),
        .boundary_i  (boundary),
        .act_code_o  (act_code),
        .next_code_o (next_code),
        .bad_o       (code_bad_o)
    );

    busclk_phase_calc #(
        .CODE_W (CODE_W)
    ) i_phase_calc (
        .code_i (act_code),
        .last_o (act_last),
        .high_o (act_high)
    );

    busclk_wave #(
        .CODE_W (CODE_W)
    ) i_wave (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .act_last_i  (act_last),
        .act_high_i  (act_high),
        .next_code_i (next_code),
        .boundary_o  (boundary),
        .bus_clk_o   (bus_clk_o),
        .rise_o      (rise_stb_o),
        .fall_o      (fall_stb_o)
    );

    // R7: a legal load into a stopped output starts the clock at once
    assert_start_from_idle_R7: assert property (
        @(posedge clk_i) disable iff (rst_i)
        (div_load_i && div_code_i != '0 && act_code == '0) |=> rise_stb_o
    );

endmodule

// File: tb/test_busclk_divider.sv
module test_busclk_divider;

    localparam int CODE_W = 5;

    logic clk = 1'b0;
    logic rst;
    logic [CODE_W-1:0] code_r;
    logic load_r;
    logic bus_clk, rise_stb, fall_stb, code_bad;

    int nchk = 0;
    int nerr = 0;
    int strobe_err = 0;
    logic prev_clk = 1'b0;
    logic rst_at_edge = 1'b1;

    always #5 clk = ~clk;

    busclk_divider #(.CODE_W(CODE_W)) i_busclk_divider (
        .clk_i      (clk),
        .rst_i      (rst),
        .div_code_i (code_r),
        .div_load_i (load_r),
        .bus_clk_o  (bus_clk),
        .rise_stb_o (rise_stb),
        .fall_stb_o (fall_stb),
        .code_bad_o (code_bad)
    );

    typedef struct packed {
        logic [7:0] code;
        logic [7:0] hi;
        logic [7:0] lo;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{8'd1,  8'd1,  8'd1},
        '{8'd2,  8'd2,  8'd1},
        '{8'd3,  8'd2,  8'd2},
        '{8'd4,  8'd3,  8'd2},
        '{8'd7,  8'd4,  8'd4},
        '{8'd8,  8'd5,  8'd4},
        '{8'd15, 8'd8,  8'd8},
        '{8'd30, 8'd16, 8'd15},
        '{8'd31, 8'd16, 8'd16}
    };

    // R9 monitor: strobes must match the observed transitions
    always @(posedge clk) rst_at_edge <= rst;
    always @(negedge clk) begin
        if (!rst_at_edge) begin
            if (rise_stb !== (bus_clk & ~prev_clk)) strobe_err++;
            if (fall_stb !== (~bus_clk & prev_clk)) strobe_err++;
        end
        prev_clk = bus_clk;
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        load_r = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic load_code(input int c);
        code_r = CODE_W'(c);
        load_r = 1'b1;
        @(negedge clk);
        load_r = 1'b0;
    endtask

    // starts on a cycle where the clock has just risen
    task automatic measure(output int h, output int l);
        h = 0;
        l = 0;
        while (bus_clk === 1'b1 && h < 100) begin
            h++;
            @(negedge clk);
        end
        while (bus_clk === 1'b0 && l < 100) begin
            l++;
            @(negedge clk);
        end
    endtask

    task automatic steps_to_rise(output int n);
        n = 0;
        while (rise_stb !== 1'b1 && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int h, l, n, r, f;
        string tag;
        code_r = '0;
        load_r = 1'b0;
        rst    = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state, stopped until a code arrives
        chk("R10 clk", int'(bus_clk), 0);
        chk("R10 rise", int'(rise_stb), 0);
        chk("R10 fall", int'(fall_stb), 0);
        chk("R10 flag", int'(code_bad), 0);
        r = 0;
        repeat (12) begin
            @(negedge clk);
            r += int'(bus_clk);
        end
        chk("R10 no clock before load", r, 0);

        // table sweep over ratios
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            load_code(int'(VECS[i].code));
            chk("R7 start after load", int'(rise_stb), 1);
            measure(h, l);
            if (VECS[i].code == 8'd1)       tag = "R4";
            else if (VECS[i].code == 8'd31) tag = "R5";
            else if (VECS[i].code[0])       tag = "R2";
            else                            tag = "R3";
            chk({tag, " high"}, h, int'(VECS[i].hi));
            chk({tag, " low"}, l, int'(VECS[i].lo));
            measure(h, l);
            chk("R1 period", h + l, int'(VECS[i].code) + 1);
        end

        // R8: change during high phase, then last-of-two wins
        do_reset();
        load_code(3);
        load_code(5);
        steps_to_rise(n);
        chk("R8 old period completes", n, 3);
        measure(h, l);
        chk("R8 new code high", h, 3);
        chk("R8 new code low", l, 3);
        load_code(5);
        load_code(9);
        steps_to_rise(n);
        chk("R8 remainder before boundary", n, 4);
        measure(h, l);
        chk("R8 last load wins", h + l, 10);

        // R8: load in the final cycle of a period
        repeat (9) @(negedge clk);
        load_code(2);
        chk("R8 boundary load rise", int'(rise_stb), 1);
        measure(h, l);
        chk("R8 boundary load high", h, 2);
        chk("R8 boundary load low", l, 1);

        // R6: zero code while running
        load_code(0);
        chk("R6 flag raised", int'(code_bad), 1);
        chk("R6 period not cut", int'(bus_clk), 1);
        r = 0;
        f = 0;
        repeat (30) begin
            @(negedge clk);
            r += int'(rise_stb);
            f += int'(fall_stb);
        end
        chk("R6 no rising edge", r, 0);
        chk("R6 single fall", f, 1);
        chk("R6 held low", int'(bus_clk), 0);

        // R7: legal code restarts and clears the flag
        load_code(4);
        chk("R7 flag cleared", int'(code_bad), 0);
        chk("R7 restart rise", int'(rise_stb), 1);
        measure(h, l);
        chk("R3 restart high", h, 3);
        chk("R3 restart low", l, 2);

        // R6: zero code from stop keeps the output low
        do_reset();
        load_code(0);
        chk("R6 flag from idle", int'(code_bad), 1);
        r = 0;
        repeat (20) begin
            @(negedge clk);
            r += int'(bus_clk);
        end
        chk("R6 idle stays low", r, 0);

        // R10: reset in mid-run
        load_code(6);
        repeat (2) @(negedge clk);
        do_reset();
        chk("R10 mid-run clk", int'(bus_clk), 0);
        chk("R10 mid-run flag", int'(code_bad), 0);
        r = 0;
        repeat (15) begin
            @(negedge clk);
            r += int'(rise_stb);
        end
        chk("R10 no edges after reset", r, 0);

        chk("R9 strobe alignment", strobe_err, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule